// File: doc/BRIEF.md
# Thread Block Dispatcher with Admission Control

This block takes one launch at a time, made of a number of equal-sized thread blocks, and hands each block as a whole to one of several compute units. Each unit has two independent budgets: resident thread slots and resident block slots. A block goes to a unit only when that unit can take all of the block's threads and still has a free block slot. A block is never split, so a unit never holds part of a block while the rest waits, and that partial-placement deadlock cannot arise.

Blocks that find no room stay pending. When a unit reports that one of its blocks has finished, the unit gets back that block's threads and its block slot, and the pending blocks are placed again. Units are searched round-robin, starting after the unit chosen last. At most one block is placed per cycle. A launch whose per-block thread count is zero or above the per-block limit is refused with an error flag. Done rises once every block of the launch has been placed and has finished.

Top module: `blk_dispatch`

## Requirements
- R1: Every placement names exactly one unit, with an index below NUM_UNITS. Within a launch, block indices are issued as 0, 1, 2, ... with no gap and no repeat.
- R2: A block is placed on a unit only if the unit's free thread slots are at least the block's thread count. With the defaults (2048 slots per unit, 4 units) and 768-thread blocks, at most 2 blocks go to each unit, so 8 are placed and the rest wait.
- R3: A unit never holds more than UNIT_BLOCKS blocks. With 32-thread blocks and the default cap of 32, a unit stops at 32 blocks (1024 threads), so 128 blocks are placed over 4 units.
- R4: A pending block is placed once a retirement frees enough room. It goes to the unit that freed the room, and it takes the next block index.
- R5: The unit search is round-robin and starts at the unit after the last one chosen. The first placement after reset goes to unit 0. While all units fit, placements come on consecutive cycles and cycle through units 0,1,2,3,0,...
- R6: A retire pulse on a unit gives back one block slot and one block's worth of threads, and both take effect at the clock edge of the pulse. A retire pulse on a unit with no resident block is ignored.
- R7: A launch with a thread count of 0, or above MAX_BLK_THREADS (1024), sets launch_err one cycle later and places nothing. A thread count of exactly 1024 is accepted. launch_err clears when a valid launch is accepted.
- R8: done rises only after every block of the launch has been placed and has retired. It clears when the next launch is accepted. A launch request made while a launch is still running is ignored.
- R9: After reset, assign_valid, done and launch_err are 0, and every unit has all its thread slots and block slots free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_valid | input | 1 | One-cycle launch request pulse; taken only while idle |
| launch_blocks | input | CNT_W | Number of blocks in the launch |
| launch_threads | input | clog2(2*MAX_BLK_THREADS) | Threads per block |
| retire | input | NUM_UNITS | One bit per unit; a pulse means one resident block on that unit finished |
| assign_valid | output | 1 | A block was placed this cycle |
| assign_unit | output | clog2(NUM_UNITS) | Unit that received the block |
| assign_block | output | CNT_W | Index of the placed block within the launch |
| launch_err | output | 1 | The last launch request was refused |
| done | output | 1 | All blocks of the launch were placed and have retired |

## Verification
The bench runs five launch shapes. Small 256-thread blocks fit everywhere, so they show the plain round-robin order and the block numbering. 768-thread and 1024-thread blocks fill the thread budget before the block budget, while 32-thread blocks fill the block budget first, so the two caps are told apart by where placement stops. Retiring one block on one unit during a stall shows whether that unit's freed room is reused at once. A single-block launch with a retire pulse sent to an empty unit shows whether stray pulses are ignored or wrongly counted toward done. Refused and boundary thread counts separate the error path from normal admission.

// File: rtl/blk_dispatch_pkg.sv
// Package: shared types for the thread block dispatcher.
// Assumes: nothing beyond IEEE 1800-2017.
package blk_dispatch_pkg;

    // Controller states: waiting for a launch, or placing/draining one.
    typedef enum logic {
        DS_IDLE = 1'b0,
        DS_RUN  = 1'b1
    } disp_state_e;

endpackage

// File: rtl/unit_ledger.sv
// Module: unit_ledger
// Keeps the free thread-slot and free block-slot counts of one compute unit
// and reports whether a block of the current size fits on it.
// Assumes: blk_threads <= UNIT_THREADS, and take is asserted only when fits is 1.
module unit_ledger #(
    parameter int UNIT_THREADS = 2048,
    parameter int UNIT_BLOCKS  = 32,
    localparam int TW = $clog2(UNIT_THREADS + 1),
    localparam int BW = $clog2(UNIT_BLOCKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] blk_threads,
    input  logic          take,
    input  logic          retire,
    output logic [TW-1:0] free_thr,
    output logic [BW-1:0] free_blk,
    output logic          fits,
    output logic          retire_ok
);

    logic [TW-1:0] thr_back;
    logic [TW-1:0] thr_out;

    // A retire counts only when the unit has at least one resident block.
    assign retire_ok = retire && (free_blk != BW'(UNIT_BLOCKS));

    // Admission test: the whole block must fit, and a block slot must be free.
    assign fits = (free_thr >= blk_threads) && (free_blk != '0);

    // Amounts returned and consumed this cycle.
    always_comb begin
        thr_back = retire_ok ? blk_threads : '0;
        thr_out  = take ? blk_threads : '0;
    end

    // Counter update: retirement and placement may land on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_thr <= TW'(UNIT_THREADS);
            free_blk <= BW'(UNIT_BLOCKS);
        end else begin
            free_thr <= free_thr + thr_back - thr_out;
            free_blk <= free_blk + BW'(retire_ok) - BW'(take);
        end
    end

endmodule

// File: rtl/rr_pick.sv
// Module: rr_pick
// Round-robin selector: returns the first requesting index found after ptr,
// wrapping around, with ptr itself checked last.
// Assumes: N >= 1; purely combinational.
module rr_pick #(
    parameter int N = 4,
    localparam int UW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [UW-1:0] ptr,
    output logic          valid,
    output logic [UW-1:0] idx
);

    // Scan N candidates starting one past the pointer.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = 1; i <= N; i++) begin
            int cand;
            cand = (int'(ptr) + i) % N;
            if (!valid && req[cand]) begin
                valid = 1'b1;
                idx   = UW'(cand);
            end
        end
    end

endmodule

// File: rtl/blk_dispatch.sv
// Module: blk_dispatch (top)
// Accepts a launch of equal-sized thread blocks and places each block whole
// on one compute unit that has room for all its threads and a free block
// slot. At most one block per cycle; units are searched round-robin.
// Assumes: one launch at a time; a retire pulse means one block of the
// current launch finished on that unit; MAX_BLK_THREADS <= UNIT_THREADS.
module blk_dispatch
    import blk_dispatch_pkg::*;
#(
    parameter int NUM_UNITS       = 4,
    parameter int UNIT_THREADS    = 2048,
    parameter int UNIT_BLOCKS     = 32,
    parameter int MAX_BLK_THREADS = 1024,
    parameter int CNT_W           = 16,
    localparam int UW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int LW = $clog2(2 * MAX_BLK_THREADS),
    localparam int TW = $clog2(UNIT_THREADS + 1),
    localparam int BW = $clog2(UNIT_BLOCKS + 1),
    localparam int OW = $clog2(NUM_UNITS * UNIT_BLOCKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_valid,
    input  logic [CNT_W-1:0]     launch_blocks,
    input  logic [LW-1:0]        launch_threads,
    input  logic [NUM_UNITS-1:0] retire,
    output logic                 assign_valid,
    output logic [UW-1:0]        assign_unit,
    output logic [CNT_W-1:0]     assign_block,
    output logic                 launch_err,
    output logic                 done
);

    disp_state_e                  state;
    logic [TW-1:0]                blk_threads;
    logic [CNT_W-1:0]             total_blocks;
    logic [CNT_W-1:0]             issued;
    logic [OW-1:0]                resident;
    logic [UW-1:0]                rr_ptr;
    logic [NUM_UNITS-1:0]         fit_vec;
    logic [NUM_UNITS-1:0]         take_vec;
    logic [NUM_UNITS-1:0]         ret_ok_vec;
    logic [NUM_UNITS-1:0][TW-1:0] unit_free_thr;
    logic [NUM_UNITS-1:0][BW-1:0] unit_free_blk;
    logic                         pick_valid;
    logic [UW-1:0]                pick_idx;
    logic                         place;
    logic                         launch_bad;
    logic [OW-1:0]                ret_cnt;

    // Per-unit resource ledgers.
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        unit_ledger #(
            .UNIT_THREADS(UNIT_THREADS),
            .UNIT_BLOCKS (UNIT_BLOCKS)
        ) u_ledger (
            .clk        (clk),
            .rst_n      (rst_n),
            .blk_threads(blk_threads),
            .take       (take_vec[u]),
            .retire     (retire[u]),
            .free_thr   (unit_free_thr[u]),
            .free_blk   (unit_free_blk[u]),
            .fits       (fit_vec[u]),
            .retire_ok  (ret_ok_vec[u])
        );
    end

    // Round-robin choice among the units that can take the next block.
    rr_pick #(.N(NUM_UNITS)) u_pick (
        .req  (fit_vec),
        .ptr  (rr_ptr),
        .valid(pick_valid),
        .idx  (pick_idx)
    );

    // Placement decision and one-hot take strobe for the chosen unit.
    always_comb begin
        place    = (state == DS_RUN) && (issued != total_blocks) && pick_valid;
        take_vec = '0;
        if (place) begin
            take_vec[pick_idx] = 1'b1;
        end
    end

    // Launch screening: zero or oversize blocks are refused.
    assign launch_bad = (launch_threads == '0) || (int'(launch_threads) > MAX_BLK_THREADS);

    // Number of retirements that count this cycle.
    assign ret_cnt = OW'($countones(ret_ok_vec));

    // Launch acceptance, placement bookkeeping and completion detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= DS_IDLE;
            blk_threads  <= '0;
            total_blocks <= '0;
            issued       <= '0;
            resident     <= '0;
            rr_ptr       <= UW'(NUM_UNITS - 1);
            assign_valid <= 1'b0;
            assign_unit  <= '0;
            assign_block <= '0;
            launch_err   <= 1'b0;
            done         <= 1'b0;
        end else begin
            assign_valid <= place;
            resident     <= resident + OW'(place) - ret_cnt;
            if (place) begin
                assign_unit  <= pick_idx;
                assign_block <= issued;
                issued       <= issued + 1'b1;
                rr_ptr       <= pick_idx;
            end
            case (state)
                DS_IDLE: begin
                    if (launch_valid) begin
                        done       <= 1'b0;
                        launch_err <= launch_bad;
                        if (!launch_bad) begin
                            blk_threads  <= TW'(launch_threads);
                            total_blocks <= launch_blocks;
                            issued       <= '0;
                            state        <= DS_RUN;
                        end
                    end
                end
                DS_RUN: begin
                    if (issued == total_blocks && resident == '0) begin
                        done  <= 1'b1;
                        state <= DS_IDLE;
                    end
                end
                default: state <= DS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/blk_dispatch_chk.sv
// Module: blk_dispatch_chk
// Assertion checker bound to blk_dispatch; it watches the ports and the
// per-unit free counts. Assumes the same parameters as the bound instance.
module blk_dispatch_chk #(
    parameter int NUM_UNITS    = 4,
    parameter int UNIT_THREADS = 2048,
    parameter int UNIT_BLOCKS  = 32,
    parameter int CNT_W        = 16,
    localparam int UW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int TW = $clog2(UNIT_THREADS + 1),
    localparam int BW = $clog2(UNIT_BLOCKS + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         assign_valid,
    input logic [UW-1:0]                assign_unit,
    input logic [CNT_W-1:0]             assign_block,
    input logic                         launch_err,
    input logic                         done,
    input logic [NUM_UNITS-1:0][TW-1:0] unit_free_thr,
    input logic [NUM_UNITS-1:0][BW-1:0] unit_free_blk
);

    // R1: the chosen unit exists.
    a_r1_unit_range: assert property (@(posedge clk) disable iff (!rst_n)
        assign_valid |-> (int'(assign_unit) < NUM_UNITS));

    // R1: back-to-back placements carry consecutive block indices.
    a_r1_block_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (assign_valid && $past(assign_valid)) |-> (assign_block == $past(assign_block) + 1'b1));

    // R7: a refused launch places nothing.
    a_r7_err_no_assign: assert property (@(posedge clk) disable iff (!rst_n)
        launch_err |-> !assign_valid);

    // R8: nothing is placed once the launch is done.
    a_r8_done_no_assign: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !assign_valid);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_caps
        // R2: free thread slots never exceed the unit budget.
        a_r2_thread_cap: assert property (@(posedge clk) disable iff (!rst_n)
            int'(unit_free_thr[u]) <= UNIT_THREADS);
        // R3: free block slots never exceed the unit budget.
        a_r3_block_cap: assert property (@(posedge clk) disable iff (!rst_n)
            int'(unit_free_blk[u]) <= UNIT_BLOCKS);
    end

endmodule

bind blk_dispatch blk_dispatch_chk #(
    .NUM_UNITS   (NUM_UNITS),
    .UNIT_THREADS(UNIT_THREADS),
    .UNIT_BLOCKS (UNIT_BLOCKS),
    .CNT_W       (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .assign_valid (assign_valid),
    .assign_unit  (assign_unit),
    .assign_block (assign_block),
    .launch_err   (launch_err),
    .done         (done),
    .unit_free_thr(unit_free_thr),
    .unit_free_blk(unit_free_blk)
);

// File: tb/blk_dispatch_tb.sv
// Bench: directed scenarios for blk_dispatch, one task each.
module blk_dispatch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NU         = 4;
    localparam int CW         = 16;
    localparam int LW         = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          launch_valid = 1'b0;
    logic [CW-1:0] launch_blocks = '0;
    logic [LW-1:0] launch_threads = '0;
    logic [NU-1:0] retire = '0;
    logic          assign_valid;
    logic [1:0]    assign_unit;
    logic [CW-1:0] assign_block;
    logic          launch_err;
    logic          done;

    int n_tests = 0;
    int n_fail  = 0;
    int n_asg   = 0;
    int asg_cnt [NU];
    int ret_cnt [NU];
    int seq_u   [1024];
    int seq_b   [1024];
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_dispatch u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch_valid  (launch_valid),
        .launch_blocks (launch_blocks),
        .launch_threads(launch_threads),
        .retire        (retire),
        .assign_valid  (assign_valid),
        .assign_unit   (assign_unit),
        .assign_block  (assign_block),
        .launch_err    (launch_err),
        .done          (done)
    );

    // Monitor: record every placement, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && assign_valid) begin
            asg_cnt[assign_unit] = asg_cnt[assign_unit] + 1;
            if (n_asg < 1024) begin
                seq_u[n_asg] = int'(assign_unit);
                seq_b[n_asg] = int'(assign_block);
            end
            n_asg = n_asg + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic launch(input int blocks, input int threads);
        @(negedge clk);
        launch_valid   = 1'b1;
        launch_blocks  = CW'(blocks);
        launch_threads = LW'(threads);
        @(negedge clk);
        launch_valid   = 1'b0;
    endtask

    task automatic pulse_retire(input int u);
        @(negedge clk);
        retire[u] = 1'b1;
        @(negedge clk);
        retire = '0;
    endtask

    // Retire every resident block one at a time until nothing is left.
    task automatic drain();
        for (int k = 0; k < 2000; k++) begin
            bit any;
            any = 1'b0;
            for (int u = 0; u < NU; u++) begin
                if (!any && asg_cnt[u] > ret_cnt[u]) begin
                    any = 1'b1;
                    ret_cnt[u]++;
                    pulse_retire(u);
                    wait_cyc(2);
                end
            end
            if (!any) break;
        end
        wait_cyc(2);
    endtask

    function automatic int resident_on(input int u);
        return asg_cnt[u] - ret_cnt[u];
    endfunction

    // R9: reset state.
    task automatic t_reset();
        check(assign_valid == 1'b0, "R9 assign_valid after reset", int'(assign_valid), 0);
        check(done == 1'b0, "R9 done after reset", int'(done), 0);
        check(launch_err == 1'b0, "R9 launch_err after reset", int'(launch_err), 0);
    endtask

    // R7: zero and oversize thread counts are refused, nothing placed.
    task automatic t_reject();
        int base;
        base = n_asg;
        launch(3, 1025);
        wait_cyc(4);
        check(launch_err == 1'b1, "R7 err on 1025 threads", int'(launch_err), 1);
        check(n_asg == base, "R7 no placement on refusal", n_asg - base, 0);
        launch(3, 0);
        wait_cyc(4);
        check(launch_err == 1'b1, "R7 err on 0 threads", int'(launch_err), 1);
        check(done == 1'b0, "R8 no done after refusal", int'(done), 0);
        check(n_asg == base, "R7 no placement on zero", n_asg - base, 0);
    endtask

    // R1/R5: small blocks, round-robin from unit 0, consecutive indices.
    task automatic t_round_robin();
        int base;
        base = n_asg;
        launch(6, 256);
        check(launch_err == 1'b0, "R7 err cleared on valid launch", int'(launch_err), 0);
        wait_cyc(10);
        check(n_asg - base == 6, "R5 six placements", n_asg - base, 6);
        for (int i = 0; i < 6; i++) begin
            check(seq_u[base+i] == i % NU, "R5 round-robin unit order", seq_u[base+i], i % NU);
            check(seq_b[base+i] == i, "R1 block index order", seq_b[base+i], i);
        end
        check(done == 1'b0, "R8 not done while blocks resident", int'(done), 0);
        drain();
        check(done == 1'b1, "R8 done after all retired", int'(done), 1);
    endtask

    // R2/R4/R6/R8: 768-thread blocks fill units at 2 each; a retire frees room.
    task automatic t_thread_cap();
        int base;
        base = n_asg;
        launch(10, 768);
        check(done == 1'b0, "R8 done cleared on launch", int'(done), 0);
        wait_cyc(20);
        check(n_asg - base == 8, "R2 only eight 768-thread blocks fit", n_asg - base, 8);
        for (int u = 0; u < NU; u++)
            check(resident_on(u) == 2, "R2 two blocks per unit", resident_on(u), 2);
        // R8: a launch request while running is ignored.
        launch(5, 64);
        wait_cyc(4);
        check(n_asg - base == 8, "R8 launch ignored while busy", n_asg - base, 8);
        ret_cnt[2]++;
        pulse_retire(2);
        wait_cyc(4);
        check(n_asg - base == 9, "R4 pending block placed after retire", n_asg - base, 9);
        check(seq_u[base+8] == 2, "R4 placed on freed unit", seq_u[base+8], 2);
        check(seq_b[base+8] == 8, "R1 next block index", seq_b[base+8], 8);
        drain();
        check(n_asg - base == 10, "R4 all blocks eventually placed", n_asg - base, 10);
        check(done == 1'b1, "R8 done after thread-cap launch", int'(done), 1);
    endtask

    // R3: 32-thread blocks stop at 32 per unit.
    task automatic t_block_cap();
        int base;
        base = n_asg;
        launch(200, 32);
        wait_cyc(150);
        check(n_asg - base == 128, "R3 block-slot cap stops at 128", n_asg - base, 128);
        for (int u = 0; u < NU; u++)
            check(resident_on(u) == 32, "R3 32 blocks per unit", resident_on(u), 32);
        drain();
        check(n_asg - base == 200, "R3 all 200 placed", n_asg - base, 200);
        check(done == 1'b1, "R8 done after block-cap launch", int'(done), 1);
    endtask

    // R7 boundary: exactly 1024 threads accepted, 2 per unit.
    task automatic t_max_block();
        int base;
        base = n_asg;
        launch(9, 1024);
        wait_cyc(20);
        check(launch_err == 1'b0, "R7 1024 threads accepted", int'(launch_err), 0);
        check(n_asg - base == 8, "R2 eight 1024-thread blocks fit", n_asg - base, 8);
        drain();
        check(done == 1'b1, "R8 done after max-size launch", int'(done), 1);
    endtask

    // R6: a retire on an empty unit is ignored.
    task automatic t_stray_retire();
        int base;
        int u;
        int other;
        base = n_asg;
        launch(1, 512);
        wait_cyc(4);
        check(n_asg - base == 1, "R6 single block placed", n_asg - base, 1);
        u = seq_u[base];
        other = (u + 1) % NU;
        pulse_retire(other);
        wait_cyc(4);
        check(done == 1'b0, "R6 stray retire ignored", int'(done), 0);
        drain();
        check(done == 1'b1, "R6 real retire completes launch", int'(done), 1);
    endtask

    initial begin
        for (int u = 0; u < NU; u++) begin
            asg_cnt[u] = 0;
            ret_cnt[u] = 0;
        end
        wait_cyc(4);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_reject();
        t_round_robin();
        t_thread_cap();
        t_block_cap();
        t_max_block();
        t_stray_retire();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule